// File: doc/BRIEF.md
# Two-Wire Slave Port for a 16-bit Register Bank

This block is a serial slave on a two-wire bus: one clock line and one open-drain data line. It gives an on-chip bank of 16-bit registers to an external bus master. Both bus lines are sampled by a faster system clock, pass through a synchronizer, and are turned into clock-edge, start and stop events. A byte-level state machine decodes the device address and acknowledges the bytes it receives. It also shifts out read data. A register layer above it keeps an 8-bit register pointer. It puts pairs of bytes together into 16-bit words and drives a simple internal register-file port.

Two strap pins select one of four device addresses. A write gives the register address and then pairs of data bytes, most significant byte first. Each complete pair writes one register, and the pointer then moves to the next register. A read first writes the register address, then sends a repeated start with the read address. The slave returns the high byte and then the low byte of each register, and the pointer advances after every word. The master ends a read with a not-acknowledge.

Masters that can only move one byte at a time use a byte-wise access register at address 0xF0. To write, the master sends only the high byte to the target register, then sends the low byte to 0xF0, which writes the whole word. To read, the master reads the high byte of the target register, then reads 0xF0 to get the low byte that was latched.

Top module: `twowire_reg16_slave`

## Requirements
- R1: A start (data falling while clock is high) begins a new transfer and a stop (data rising while clock is high) ends it. After either event the slave releases the data line, and out of reset it drives nothing and writes nothing.
- R2: The slave changes its data-line drive only while the synchronized clock line is low.
- R3: The 7-bit device address comes from the straps, giving 8-bit address bytes of 0x90, 0x98, 0xB0 and 0xB8 for straps 0 to 3. Address bit 0 set to 1 selects a read.
- R4: An address byte that does not match is not acknowledged, and the slave then neither acknowledges nor writes anything until the next start or stop.
- R5: In a write, the slave acknowledges (holds the data line low) its address byte, the register address byte and every data byte.
- R6: A register is written with {high byte, low byte} only after both bytes are received. This is a single one-cycle write pulse on the register-file port. A high byte alone followed by a stop leaves the register unchanged.
- R7: After each written word the register pointer increments, so a write burst fills consecutive registers.
- R8: A read is a register-address write, then a repeated start and the read address. The slave then sends the addressed register's high byte followed by its low byte.
- R9: During a read the pointer advances after each word, so a burst returns consecutive registers. A not-acknowledge from the master makes the slave release the data line for the rest of the transfer.
- R10: Writing one byte to address 0xF0 writes {last lone high byte, that byte} to the register the lone high byte was aimed at.
- R11: After the high byte of register A has been read, the first byte read from address 0xF0 is the low byte of A.
- R12: Address 0xF0 is never presented as a write target on the register-file port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull the data line low when 1 (open drain) |
| strap | input | 2 | Device address select |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_addr | output | REG_AW | Register-file address (write target while rf_we, otherwise the read pointer) |
| rf_wdata | output | REG_DW | Register-file write data |
| rf_rdata | input | REG_DW | Register-file read data for rf_addr, combinational |

## Verification
The assertions assume a well-behaved master. The bus clock holds each level for several system clocks, and the data line moves only while the clock is low, except when the master makes a start or stop. The master also never drives the line low in a slot the slave owns. The stimulus keeps within these limits by building every bit from quarter periods of six system clocks. Data changes one quarter after the clock falls, and the line is sampled halfway through the clock-high period. With that spacing, every drive change the slave makes lands well inside the clock-low window.

// File: rtl/tw16_pkg.sv
package tw16_pkg;

   typedef enum logic [2:0] {
      LK_IDLE,
      LK_RX,
      LK_ACKO,
      LK_TX,
      LK_ACKI,
      LK_SKIP
   } lk_state_t;

   typedef enum logic [1:0] {
      WC_REG,
      WC_HI,
      WC_LO,
      WC_BSKIP
   } wctx_t;

   function automatic logic [6:0] strap_to_dev(input logic [6:0] base, input logic [1:0] s);
      return base | {2'b00, s[1], 1'b0, s[0], 2'b00};
   endfunction

endpackage

// File: rtl/tw16_sync.sv
module tw16_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tw16_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tw16_link.sv
module tw16_link
   import tw16_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [BYTE_W-2:0] dev7,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              sda_oe,
   output logic              wr_vld,
   output logic [BYTE_W-1:0] wr_data,
   output logic              rd_take
);

   localparam int CW = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0] FULL = CW'(BYTE_W);
   localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

   lk_state_t         state;
   logic [CW-1:0]     cnt;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] txsh;
   logic              first;
   logic              rd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= LK_IDLE;
         cnt     <= '0;
         sh      <= '0;
         txsh    <= '0;
         first   <= 1'b0;
         rd_mode <= 1'b0;
         sda_oe  <= 1'b0;
         wr_vld  <= 1'b0;
         wr_data <= '0;
         rd_take <= 1'b0;
      end else begin
         wr_vld  <= 1'b0;
         rd_take <= 1'b0;
         if (start_evt) begin
            state   <= LK_RX;
            cnt     <= '0;
            first   <= 1'b1;
            rd_mode <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_evt) begin
            state  <= LK_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               LK_RX: begin
                  if (scl_rise && cnt < FULL) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == FULL) begin
                     first <= 1'b0;
                     if (first) begin
                        if (sh[BYTE_W-1:1] == dev7) begin
                           rd_mode <= sh[0];
                           sda_oe  <= 1'b1;
                           state   <= LK_ACKO;
                        end else begin
                           state <= LK_SKIP;
                        end
                     end else begin
                        wr_vld  <= 1'b1;
                        wr_data <= sh;
                        sda_oe  <= 1'b1;
                        state   <= LK_ACKO;
                     end
                  end
               end
               LK_ACKO: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (rd_mode) begin
                        txsh    <= tx_byte;
                        rd_take <= 1'b1;
                        sda_oe  <= ~tx_byte[BYTE_W-1];
                        state   <= LK_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= LK_RX;
                     end
                  end
               end
               LK_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST) begin
                        sda_oe <= 1'b0;
                        state  <= LK_ACKI;
                     end else begin
                        txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txsh[BYTE_W-2];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               LK_ACKI: begin
                  if (scl_rise) begin
                     if (sda_s) state <= LK_SKIP;
                  end else if (scl_fall) begin
                     cnt     <= '0;
                     txsh    <= tx_byte;
                     rd_take <= 1'b1;
                     sda_oe  <= ~tx_byte[BYTE_W-1];
                     state   <= LK_TX;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R2
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R1
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe);

   // R1
   start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_oe);

endmodule

// File: rtl/tw16_regs.sv
module tw16_regs
   import tw16_pkg::*;
#(
   parameter int          REG_AW    = 8,
   parameter int          REG_DW    = 16,
   parameter bit          BYTE_EN   = 1'b1,
   parameter logic [7:0]  BYTE_ADDR = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_evt,
   input  logic              wr_vld,
   input  logic [7:0]        wr_data,
   input  logic              rd_take,
   output logic [7:0]        tx_byte,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_addr,
   output logic [REG_DW-1:0] rf_wdata,
   input  logic [REG_DW-1:0] rf_rdata
);

   localparam int HW = REG_DW / 2;

   if (REG_DW != 16) begin : g_bad_dw
      $error("tw16_regs: REG_DW must be 16");
   end
   if (REG_AW > 8 || REG_AW < 1) begin : g_bad_aw
      $error("tw16_regs: REG_AW must be 1 to 8");
   end

   wctx_t             wctx;
   logic [REG_AW-1:0] ptr;
   logic [REG_AW-1:0] wr_addr_q;
   logic [REG_AW-1:0] pend_addr;
   logic              pend_vld;
   logic [HW-1:0]     hi_q;
   logic [HW-1:0]     lo_hold;
   logic [HW-1:0]     shadow;
   logic              rd_half;
   logic              is_b;

   if (BYTE_EN) begin : g_byte
      assign is_b = (ptr == BYTE_ADDR[REG_AW-1:0]);
   end else begin : g_nobyte
      assign is_b = 1'b0;
   end

   assign tx_byte = rd_half ? lo_hold : (is_b ? shadow : rf_rdata[REG_DW-1:HW]);
   assign rf_addr = rf_we ? wr_addr_q : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wctx      <= WC_REG;
         ptr       <= '0;
         wr_addr_q <= '0;
         pend_addr <= '0;
         pend_vld  <= 1'b0;
         hi_q      <= '0;
         lo_hold   <= '0;
         shadow    <= '0;
         rd_half   <= 1'b0;
         rf_we     <= 1'b0;
         rf_wdata  <= '0;
      end else begin
         rf_we <= 1'b0;
         if (start_evt) begin
            wctx    <= WC_REG;
            rd_half <= 1'b0;
         end else if (wr_vld) begin
            case (wctx)
               WC_REG: begin
                  ptr  <= wr_data[REG_AW-1:0];
                  wctx <= WC_HI;
               end
               WC_HI: begin
                  if (is_b) begin
                     if (pend_vld) begin
                        rf_we     <= 1'b1;
                        wr_addr_q <= pend_addr;
                        rf_wdata  <= {hi_q, wr_data};
                        pend_vld  <= 1'b0;
                     end
                     wctx <= WC_BSKIP;
                  end else begin
                     hi_q      <= wr_data;
                     pend_addr <= ptr;
                     pend_vld  <= BYTE_EN;
                     wctx      <= WC_LO;
                  end
               end
               WC_LO: begin
                  rf_we     <= 1'b1;
                  wr_addr_q <= ptr;
                  rf_wdata  <= {hi_q, wr_data};
                  ptr       <= ptr + 1'b1;
                  pend_vld  <= 1'b0;
                  wctx      <= WC_HI;
               end
               default: ;
            endcase
         end else if (rd_take) begin
            if (!rd_half) begin
               rd_half <= 1'b1;
               lo_hold <= is_b ? '0 : rf_rdata[HW-1:0];
               if (!is_b) shadow <= rf_rdata[HW-1:0];
            end else begin
               rd_half <= 1'b0;
               ptr     <= ptr + 1'b1;
            end
         end
      end
   end

   // R6
   we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R12
   no_byte_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (!BYTE_EN || rf_addr != BYTE_ADDR[REG_AW-1:0]));

endmodule

// File: rtl/twowire_reg16_slave.sv
module twowire_reg16_slave
   import tw16_pkg::*;
#(
   parameter logic [6:0] DEV_BASE       = 7'h48,
   parameter int         SYNC_STAGES    = 2,
   parameter int         REG_AW         = 8,
   parameter int         REG_DW         = 16,
   parameter bit         BYTE_ACCESS_EN = 1'b1,
   parameter logic [7:0] BYTE_REG_ADDR  = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        strap,
   output logic              rf_we,
   output logic [REG_AW-1:0] rf_addr,
   output logic [REG_DW-1:0] rf_wdata,
   input  logic [REG_DW-1:0] rf_rdata
);

   localparam int BYTE_W = 8;

   logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic [6:0]        dev7;
   logic [BYTE_W-1:0] tx_byte, wr_data;
   logic              wr_vld, rd_take;

   assign dev7 = strap_to_dev(DEV_BASE, strap);

   tw16_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   tw16_link #(.BYTE_W(BYTE_W)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt), .dev7(dev7),
      .tx_byte(tx_byte), .sda_oe(sda_oe), .wr_vld(wr_vld),
      .wr_data(wr_data), .rd_take(rd_take)
   );

   tw16_regs #(
      .REG_AW(REG_AW), .REG_DW(REG_DW),
      .BYTE_EN(BYTE_ACCESS_EN), .BYTE_ADDR(BYTE_REG_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
      .wr_vld(wr_vld), .wr_data(wr_data), .rd_take(rd_take),
      .tx_byte(tx_byte), .rf_we(rf_we), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

endmodule

// File: tb/tb_twowire_reg16_slave.sv
module tb_twowire_reg16_slave;

   localparam int CLK_PERIOD = 10;
   localparam int QTR        = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        m_sda = 1'b1;
   logic [1:0]  strap = 2'b11;
   logic        sda_oe;
   logic        rf_we;
   logic [7:0]  rf_addr;
   logic [15:0] rf_wdata;
   logic [15:0] rf_rdata;
   logic        sda_line;

   logic [15:0] mem [256];
   int wr_cnt = 0;
   int f0_wr  = 0;
   int tests  = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;
   assign rf_rdata = mem[rf_addr];

   always @(posedge clk) begin
      if (rf_we) begin
         mem[rf_addr] <= rf_wdata;
         wr_cnt = wr_cnt + 1;
         if (rf_addr == 8'hF0) f0_wr = f0_wr + 1;
      end
   end

   twowire_reg16_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .strap(strap), .rf_we(rf_we), .rf_addr(rf_addr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

   function automatic logic [15:0] init_val(input int i);
      logic [7:0] b;
      b = i[7:0];
      return {b, ~b};
   endfunction

   function automatic logic [7:0] addr_of(input int s);
      case (s & 3)
         0: return 8'h90;
         1: return 8'h98;
         2: return 8'hB0;
         default: return 8'hB8;
      endcase
   endfunction

   task automatic wq();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bit_xfer(input logic b, output logic r);
      m_sda = b;
      wq();
      scl = 1'b1;
      wq();
      r = sda_line;
      wq();
      scl = 1'b0;
      wq();
   endtask

   task automatic bus_start();
      m_sda = 1'b1;
      wq();
      scl = 1'b1;
      wq();
      m_sda = 1'b0;
      wq();
      scl = 1'b0;
      wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0;
      wq();
      scl = 1'b1;
      wq();
      m_sda = 1'b1;
      wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) bit_xfer(b[i], r);
      bit_xfer(1'b1, ack);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_xfer(1'b1, r);
         b[i] = r;
      end
      bit_xfer(nack, r);
   endtask

   task automatic t_reset();
      chk("R1 reset sda_oe", {31'd0, sda_oe}, 32'd0);
      chk("R1 reset no write", wr_cnt, 0);
      bus_start();
      bus_stop();
      chk("R1 start+stop released", {31'd0, sda_oe}, 32'd0);
      chk("R1 start+stop no write", wr_cnt, 0);
   endtask

   task automatic t_single_write();
      logic a;
      int   w0;
      w0 = wr_cnt;
      bus_start();
      send_byte(8'hB8, a); chk("R5 ack dev addr", {31'd0, a}, 32'd0);
      send_byte(8'h09, a); chk("R5 ack reg addr", {31'd0, a}, 32'd0);
      send_byte(8'h02, a); chk("R5 ack high byte", {31'd0, a}, 32'd0);
      chk("R6 unchanged after high byte", mem[9], init_val(9));
      send_byte(8'h84, a); chk("R5 ack low byte", {31'd0, a}, 32'd0);
      bus_stop();
      chk("R6 word written", mem[9], 16'h0284);
      chk("R6 one write pulse", wr_cnt - w0, 1);
   endtask

   task automatic t_burst_write();
      logic a;
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'h20, a);
      for (int k = 1; k <= 3; k++) begin
         send_byte(8'(k * 8'h11), a);
         send_byte(8'(k * 8'h11), a);
      end
      bus_stop();
      chk("R7 burst word 0", mem[8'h20], 16'h1111);
      chk("R7 burst word 1", mem[8'h21], 16'h2222);
      chk("R7 burst word 2", mem[8'h22], 16'h3333);
      chk("R7 next reg untouched", mem[8'h23], init_val(8'h23));
   endtask

   task automatic t_read();
      logic       a;
      logic [7:0] hi, lo;
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'h30, a);
      bus_start();
      send_byte(8'hB9, a); chk("R8 ack read addr", {31'd0, a}, 32'd0);
      recv_byte(1'b0, hi);
      recv_byte(1'b1, lo);
      bus_stop();
      chk("R8 read high byte", {24'd0, hi}, 32'h30);
      chk("R8 read low byte", {24'd0, lo}, 32'hCF);
   endtask

   task automatic t_read_burst();
      logic       a, r;
      logic [7:0] b0, b1, b2, b3;
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'h40, a);
      bus_start();
      send_byte(8'hB9, a);
      recv_byte(1'b0, b0);
      recv_byte(1'b0, b1);
      recv_byte(1'b0, b2);
      recv_byte(1'b1, b3);
      chk("R9 burst bytes", {b0, b1, b2, b3}, 32'h40BF41BE);
      chk("R9 released after nack", {31'd0, sda_oe}, 32'd0);
      bit_xfer(1'b1, r);
      chk("R9 line high after nack", {31'd0, r}, 32'd1);
      bus_stop();
   endtask

   task automatic t_byte_write();
      logic a;
      int   w0;
      w0 = wr_cnt;
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'h50, a);
      send_byte(8'hAB, a);
      bus_stop();
      chk("R6 lone high byte no change", mem[8'h50], init_val(8'h50));
      chk("R6 lone high byte no pulse", wr_cnt - w0, 0);
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'hF0, a);
      send_byte(8'hCD, a); chk("R5 ack byte-wise data", {31'd0, a}, 32'd0);
      bus_stop();
      chk("R10 byte-wise commit", mem[8'h50], 16'hABCD);
      chk("R12 no write at 0xF0", f0_wr, 0);
      chk("R12 0xF0 storage untouched", mem[8'hF0], init_val(8'hF0));
   endtask

   task automatic t_byte_read();
      logic       a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'h60, a);
      bus_start();
      send_byte(8'hB9, a);
      recv_byte(1'b1, b);
      bus_stop();
      chk("R11 high byte of target", {24'd0, b}, 32'h60);
      bus_start();
      send_byte(8'hB8, a);
      send_byte(8'hF0, a);
      bus_start();
      send_byte(8'hB9, a);
      recv_byte(1'b1, b);
      bus_stop();
      chk("R11 low byte via 0xF0", {24'd0, b}, 32'h9F);
   endtask

   task automatic t_strap();
      logic       a;
      logic [7:0] b;
      int         w0;
      for (int s = 0; s < 4; s++) begin
         strap = 2'(s);
         wq();
         bus_start();
         send_byte(addr_of(s), a);
         chk($sformatf("R3 strap %0d address ack", s), {31'd0, a}, 32'd0);
         send_byte(8'(8'h70 + s), a);
         send_byte(8'(s), a);
         send_byte(8'h5A, a);
         bus_stop();
         chk($sformatf("R3 strap %0d write", s), mem[8'h70 + s], {8'(s), 8'h5A});
         w0 = wr_cnt;
         bus_start();
         send_byte(addr_of(s + 1), a);
         chk($sformatf("R4 strap %0d mismatch nack", s), {31'd0, a}, 32'd1);
         send_byte(8'h7F, a);
         chk("R4 ignored byte nack", {31'd0, a}, 32'd1);
         send_byte(8'h12, a);
         send_byte(8'h34, a);
         bus_stop();
         chk("R4 no write when ignored", wr_cnt - w0, 0);
         chk("R4 target untouched", mem[8'h7F], init_val(8'h7F));
         bus_start();
         send_byte(addr_of(s), a);
         send_byte(8'(8'h70 + s), a);
         bus_start();
         send_byte(addr_of(s) | 8'h01, a);
         chk("R3 read address ack", {31'd0, a}, 32'd0);
         recv_byte(1'b1, b);
         bus_stop();
         chk("R3 read via strap address", {24'd0, b}, 32'(s));
      end
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_single_write();
      t_burst_write();
      t_read();
      t_read_burst();
      t_byte_write();
      t_byte_read();
      t_strap();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule